// File: doc/BRIEF.md
# Reloadable 8-bit Down-Counting Timer

This block is an 8-bit down counter that steps on a count enable picked from a bank of prescaler taps. Tap n pulses once every 2^n system clocks, and a 4-bit divider select chooses which tap drives the count. A reload register holds the start value. The counter is preset from that register on a reset command and again on every underflow. Each underflow gives a one-cycle pulse, which can serve as an interrupt, as a trigger, or as the source of a serial bit clock.

A mode bit picks repeat operation or one-shot operation. In repeat mode the timer runs until software stops it. In one-shot mode the timer halts itself at the first underflow, and its run flag reads back as 0 so that software can poll for completion.

Control is a small state machine with two states, `ST_HALT` and `ST_COUNT`. It has three transitions:
- `ST_HALT` to `ST_COUNT` on a control write with the run field set to 1.
- `ST_COUNT` to `ST_HALT` on a control write with the run field set to 0.
- `ST_COUNT` to `ST_HALT` on an underflow in one-shot mode.

Top module: `reload_timer8`

## Requirements
- R1: After reset the outputs are `count_o`=0x00, `run_o`=0, `uf_o`=0, `mode_o`=0 (repeat) and `div_o`=0x0.
- R2: With `div_o`=n (0 to 14), the count moves only on cycles where `psc_tick[n]` is 1. Code 0xF is reserved and never lets the counter move.
- R3: While `psc_run` is 0, the counter does not move, even if `run_o` is 1.
- R4: A count step taken while the counter is at 0x00 is an underflow. On an underflow the counter takes the reload value, and `uf_o` is 1 for exactly the following clock cycle. Underflows are therefore (reload+1) count steps apart.
- R5: In repeat mode (`mode_o`=0), `run_o` stays 1 after an underflow and counting continues.
- R6: In one-shot mode (`mode_o`=1), after an underflow `run_o` reads 0 and the counter holds the reload value.
- R7: A control write with `ctl_rst`=1 loads the counter from the reload register, whatever the state. In the same cycle it overrides any count step, so that step produces no underflow pulse and no one-shot halt.
- R8: A control write while halted loads the run flag, the mode bit and the divider select. While counting, the mode and divider fields of a write are ignored, run=0 halts the timer, and run=1 changes nothing.
- R9: A write to the reload register (`rld_we`) leaves the current count untouched. An underflow in the same cycle as such a write loads the previous reload value, and the new value applies from the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psc_run | input | 1 | Prescaler running |
| psc_tick | input | 15 | Single-cycle enables, one per prescaler tap |
| ctl_we | input | 1 | Control write strobe |
| ctl_run | input | 1 | Run field of the control write |
| ctl_rst | input | 1 | Reset-command field (preset counter) |
| ctl_mode | input | 1 | Mode field: 0 repeat, 1 one-shot |
| ctl_div | input | 4 | Divider select field |
| rld_we | input | 1 | Reload register write strobe |
| rld_data | input | 8 | Reload write data |
| count_o | output | 8 | Current count |
| run_o | output | 1 | Run flag |
| mode_o | output | 1 | Active mode bit |
| div_o | output | 4 | Active divider select |
| uf_o | output | 1 | Underflow pulse |

## Verification
A write to the reload register can land in the same cycle as an underflow. The counter must then take the old reload value, and the newly written value must appear only at the following underflow. The bench provokes this directly. It runs with divider 0 and a short reload, waits until the count is 0x00, and writes a new reload value in that cycle. It then judges the count after the pulse and after the next pulse. A constrained-random phase also lands reset commands on underflow cycles, where the reset must win and suppress the pulse. A cycle-level model built from the requirements judges every cycle.

// File: rtl/timer8_pkg.sv
package timer8_pkg;
    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/timer8_tap_select.sv
module timer8_tap_select #(
    parameter int SEL_W = 4,
    parameter int TAPS  = 15
) (
    input  logic             psc_run,
    input  logic [TAPS-1:0]  psc_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [TAPS-1:0] hit;

    // one comparator per tap; unmatched codes (reserved) select nothing
    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        assign hit[g] = (sel == SEL_W'(g)) & psc_tick[g];
    end

    assign tick = psc_run & (|hit);
endmodule

// File: rtl/timer8_counter.sv
module timer8_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec) begin
            count <= count - W'(1);
        end
    end

    assign zero = (count == '0);
endmodule

// File: rtl/timer8_fsm.sv
module timer8_fsm
    import timer8_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_run,
    input  logic             ctl_rst,
    input  logic             ctl_mode,
    input  logic [SEL_W-1:0] ctl_div,
    input  logic             tick,
    input  logic             zero,
    output logic             running,
    output logic             mode_q,
    output logic [SEL_W-1:0] div_q,
    output logic             load,
    output logic             dec,
    output logic             uf_q
);
    tmr_state_e state, state_nx;
    logic       rst_cmd, step, uf_ev;

    assign rst_cmd = ctl_we & ctl_rst;
    assign step    = (state == ST_COUNT) & tick & ~rst_cmd;
    assign uf_ev   = step & zero;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT: begin
                if (ctl_we && ctl_run) state_nx = ST_COUNT;
            end
            ST_COUNT: begin
                if (ctl_we && !ctl_run)   state_nx = ST_HALT;
                else if (uf_ev && mode_q) state_nx = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_HALT;
            mode_q <= 1'b0;
            div_q  <= '0;
        end else begin
            state <= state_nx;
            if (ctl_we && state == ST_HALT) begin
                mode_q <= ctl_mode;
                div_q  <= ctl_div;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) uf_q <= 1'b0;
        else        uf_q <= uf_ev;
    end

    always_comb begin
        running = (state == ST_COUNT);
        load    = rst_cmd | uf_ev;
        dec     = step & ~zero;
    end
endmodule

// File: rtl/reload_timer8.sv
module reload_timer8 #(
    parameter int W     = 8,
    parameter int SEL_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  psc_run,
    input  logic [2**SEL_W-2:0]   psc_tick,
    input  logic                  ctl_we,
    input  logic                  ctl_run,
    input  logic                  ctl_rst,
    input  logic                  ctl_mode,
    input  logic [SEL_W-1:0]      ctl_div,
    input  logic                  rld_we,
    input  logic [W-1:0]          rld_data,
    output logic [W-1:0]          count_o,
    output logic                  run_o,
    output logic                  mode_o,
    output logic [SEL_W-1:0]      div_o,
    output logic                  uf_o
);
    localparam int TAPS = 2**SEL_W - 1;

    logic [W-1:0] reload_q;
    logic         tick, zero, load, dec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reload_q <= '0;
        else if (rld_we) reload_q <= rld_data;
    end

    timer8_tap_select #(.SEL_W(SEL_W), .TAPS(TAPS)) u_tap (
        .psc_run (psc_run),
        .psc_tick(psc_tick),
        .sel     (div_o),
        .tick    (tick)
    );

    timer8_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_we  (ctl_we),
        .ctl_run (ctl_run),
        .ctl_rst (ctl_rst),
        .ctl_mode(ctl_mode),
        .ctl_div (ctl_div),
        .tick    (tick),
        .zero    (zero),
        .running (run_o),
        .mode_q  (mode_o),
        .div_q   (div_o),
        .load    (load),
        .dec     (dec),
        .uf_q    (uf_o)
    );

    timer8_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .dec     (dec),
        .load_val(reload_q),
        .count   (count_o),
        .zero    (zero)
    );
endmodule

// File: rtl/reload_timer8_chk.sv
module reload_timer8_chk #(
    parameter int W     = 8,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             psc_run,
    input logic             ctl_we,
    input logic [W-1:0]     count_o,
    input logic [W-1:0]     reload_q,
    input logic             run_o,
    input logic             mode_o,
    input logic [SEL_W-1:0] div_o,
    input logic             uf_o
);
    // R4
    uf_loads_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_o |-> count_o == $past(reload_q));

    // R6
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_o && mode_o) |-> !run_o);

    // R3
    psc_stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!psc_run && !ctl_we) |=> $stable(count_o));

    // R2
    reserved_div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_o == '1 && !ctl_we) |=> $stable(count_o));

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |=> ($stable(mode_o) && $stable(div_o)));

    // R5
    repeat_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_o && !mode_o && !$past(ctl_we)) |-> run_o);
endmodule

bind reload_timer8 reload_timer8_chk #(.W(W), .SEL_W(SEL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psc_run (psc_run),
    .ctl_we  (ctl_we),
    .count_o (count_o),
    .reload_q(reload_q),
    .run_o   (run_o),
    .mode_o  (mode_o),
    .div_o   (div_o),
    .uf_o    (uf_o)
);

// File: tb/reload_timer8_tb.sv
module reload_timer8_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        psc_run;
    logic [14:0] psc_tick;
    logic        ctl_we, ctl_run, ctl_rst, ctl_mode;
    logic [3:0]  ctl_div;
    logic        rld_we;
    logic [7:0]  rld_data;
    logic [7:0]  count_o;
    logic        run_o, mode_o, uf_o;
    logic [3:0]  div_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit chk_en = 1'b0;

    always #5 clk = ~clk;

    reload_timer8 u_dut (
        .clk(clk), .rst_n(rst_n), .psc_run(psc_run), .psc_tick(psc_tick),
        .ctl_we(ctl_we), .ctl_run(ctl_run), .ctl_rst(ctl_rst),
        .ctl_mode(ctl_mode), .ctl_div(ctl_div), .rld_we(rld_we),
        .rld_data(rld_data), .count_o(count_o), .run_o(run_o),
        .mode_o(mode_o), .div_o(div_o), .uf_o(uf_o)
    );

    // bench prescaler: tap n pulses once per 2^n clocks
    logic [13:0] pc;
    always @(posedge clk) begin
        if (!rst_n)       pc <= '0;
        else if (psc_run) pc <= pc + 14'd1;
    end

    function automatic logic [13:0] tap_mask(int n);
        return 14'((1 << n) - 1);
    endfunction

    for (genvar n = 0; n < 15; n++) begin : g_tick
        assign psc_tick[n] = psc_run && ((pc & tap_mask(n)) == tap_mask(n));
    end

    // reference model built from the requirements
    logic [7:0] m_cnt, m_rld;
    logic       m_run, m_mode, m_uf;
    logic [3:0] m_div;

    function automatic logic model_tick(logic [3:0] d, logic [14:0] t, logic pr);
        if (d == 4'hF) return 1'b0;
        return pr && t[d];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_rld <= 0; m_run <= 0; m_mode <= 0; m_div <= 0; m_uf <= 0;
        end else begin
            m_uf <= 1'b0;
            if (ctl_we && ctl_rst) begin
                m_cnt <= m_rld;
            end else if (m_run && model_tick(m_div, psc_tick, psc_run)) begin
                if (m_cnt == 8'd0) begin
                    m_cnt <= m_rld;
                    m_uf  <= 1'b1;
                    if (m_mode) m_run <= 1'b0;
                end else begin
                    m_cnt <= m_cnt - 8'd1;
                end
            end
            if (ctl_we) begin
                if (!m_run) begin
                    m_run <= ctl_run; m_mode <= ctl_mode; m_div <= ctl_div;
                end else if (!ctl_run) begin
                    m_run <= 1'b0;
                end
            end
            if (rld_we) m_rld <= rld_data;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && chk_en) begin
            chk("R4 count vs model", int'(count_o), int'(m_cnt));
            chk("R6 run vs model",   int'(run_o),   int'(m_run));
            chk("R4 uf vs model",    int'(uf_o),    int'(m_uf));
            chk("R8 mode vs model",  int'(mode_o),  int'(m_mode));
            chk("R2 div vs model",   int'(div_o),   int'(m_div));
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic idle_inputs();
        ctl_we = 0; ctl_run = 0; ctl_rst = 0; ctl_mode = 0; ctl_div = 0;
        rld_we = 0; rld_data = 0;
    endtask

    task automatic ctl_write(logic run, logic rst, logic mode, logic [3:0] div);
        @(negedge clk);
        ctl_we = 1; ctl_run = run; ctl_rst = rst; ctl_mode = mode; ctl_div = div;
        @(negedge clk);
        ctl_we = 0; ctl_rst = 0;
    endtask

    task automatic rld_write(logic [7:0] v);
        @(negedge clk);
        rld_we = 1; rld_data = v;
        @(negedge clk);
        rld_we = 0;
    endtask

    task automatic wait_uf(output int at);
        at = -1;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (uf_o) begin at = cyc; return; end
        end
    endtask

    initial begin
        int t1, t2;
        void'($urandom(32'd20240611));
        idle_inputs();
        psc_run = 1;
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 count", int'(count_o), 0);
        chk("R1 run",   int'(run_o),   0);
        chk("R1 uf",    int'(uf_o),    0);
        chk("R1 mode",  int'(mode_o),  0);
        chk("R1 div",   int'(div_o),   0);
        rst_n = 1;
        chk_en = 1;

        // R4/R5: reload 3, divide by 2, repeat -> pulses 8 clocks apart
        rld_write(8'd3);
        ctl_write(1, 1, 0, 4'd1);
        wait_uf(t1);
        wait_uf(t2);
        chk("R4 period", t2 - t1, 8);
        chk("R5 still running", int'(run_o), 1);

        // R8: mode/div fields ignored while running
        ctl_write(1, 0, 1, 4'd5);
        chk("R8 mode ignored", int'(mode_o), 0);
        chk("R8 div ignored",  int'(div_o),  1);
        ctl_write(0, 0, 0, 4'd0);
        chk("R8 halted", int'(run_o), 0);

        // R9: reload write in the underflow cycle
        rld_write(8'd2);
        ctl_write(1, 1, 0, 4'd0);
        for (int k = 0; k < 50 && count_o != 8'd0; k++) @(negedge clk);
        rld_we = 1; rld_data = 8'd5;
        @(negedge clk);
        rld_we = 0;
        chk("R9 old reload used", int'(count_o), 2);
        chk("R9 pulse", int'(uf_o), 1);
        wait_uf(t1);
        chk("R9 new reload used", int'(count_o), 5);
        ctl_write(0, 0, 0, 4'd0);

        // R6: one-shot halts itself
        ctl_write(1, 1, 1, 4'd2);
        wait_uf(t1);
        chk("R6 run cleared", int'(run_o), 0);
        chk("R6 holds reload", int'(count_o), 5);
        repeat (20) @(negedge clk);
        chk("R6 no further count", int'(count_o), 5);

        // R2: reserved code never counts
        ctl_write(1, 0, 0, 4'hF);
        repeat (30) @(negedge clk);
        chk("R2 reserved holds", int'(count_o), 5);
        ctl_write(0, 0, 0, 4'd0);

        // R3: prescaler stopped
        ctl_write(1, 0, 0, 4'd0);
        psc_run = 0;
        repeat (10) @(negedge clk);
        t1 = int'(count_o);
        repeat (10) @(negedge clk);
        chk("R3 frozen", int'(count_o), t1);
        psc_run = 1;

        // constrained random, judged by the model every cycle (R7 collisions included)
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            idle_inputs();
            if ($urandom_range(0, 199) == 0) psc_run = ~psc_run;
            if ($urandom_range(0, 29) == 0) begin
                ctl_we   = 1;
                ctl_run  = ($urandom_range(0, 3) != 0);
                ctl_rst  = ($urandom_range(0, 3) == 0);
                ctl_mode = ($urandom_range(0, 2) == 0);
                ctl_div  = ($urandom_range(0, 9) == 0) ? 4'hF : 4'($urandom_range(0, 3));
            end else if (uf_o == 0 && count_o == 0 && $urandom_range(0, 3) == 0) begin
                ctl_we = 1; ctl_run = 1; ctl_rst = 1; // R7 reset on an underflow step
            end
            if ($urandom_range(0, 19) == 0) begin
                rld_we   = 1;
                rld_data = 8'($urandom_range(0, 9));
            end
        end
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule